// File: doc/BRIEF.md
# JTAG-to-SWD Switch Sequencer

This block is the host-side front end that takes a dual-mode debug port, whatever protocol it currently runs, into serial wire operation and leaves its data line in the idle state. It generates the debug clock and drives the data line itself. The switch sequence puts the port into reset with a run of high bits, sends a fixed 16-bit select pattern, resets the line again and then holds it low for a run of idle clocks. Because there is a reset on both sides of the pattern, the sequence works whether the port was in JTAG or already in serial wire mode.

After the switch sequence the block releases the line and asks the packet engine for one ID-code read. The block discards the result and waits only for the engine's acknowledge. A shorter request performs only a line reset followed by the idle run. The block does not format packets and does not check the identifier.

Each debug clock period lasts `2*HALF_DIV` system clocks. The line changes only when the debug clock falls, so the target samples stable data on the rising edge. The default lengths are 56 reset clocks and 8 idle clocks.

Top module: `swd_switch_seq`

## Requirements
- R1: After reset `dbg_clk`, `dbg_oe`, `busy`, `id_req` and `done` are all low.
- R2: A switch sequence begins with `RST_CLKS` debug clocks during which `dbg_out` is high at every rising edge of `dbg_clk`.
- R3: The next 16 debug clocks carry the select pattern 0x79E7 with the most significant bit first, which is 0xE79E with the least significant bit first.
- R4: After the pattern come another `RST_CLKS` clocks with `dbg_out` high.
- R5: The line reset is followed by `IDLE_CLKS` clocks with `dbg_out` low. No clock is added or dropped anywhere in the sequence.
- R6: After the last idle clock of a switch sequence, `id_req` goes high and stays high until `id_ack` is seen. While `id_req` is high, `dbg_oe` and `dbg_clk` are low. `done` pulses in the cycle after `id_ack` is sampled.
- R7: A line-reset request produces only `RST_CLKS` high clocks and then `IDLE_CLKS` low clocks. `done` then pulses and `id_req` never rises.
- R8: `dbg_out` changes only while `dbg_clk` is low. Rising edges of `dbg_clk` are `2*HALF_DIV` system clocks apart.
- R9: Start requests are ignored while `busy` is high. If both requests arrive in the same idle cycle, the switch sequence wins.
- R10: `done` is high for exactly one system clock per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_switch | input | 1 | Request the full switch sequence |
| start_reset | input | 1 | Request a line reset followed by idle |
| id_ack | input | 1 | Packet engine has finished the ID-code read |
| dbg_clk | output | 1 | Debug clock to the target |
| dbg_out | output | 1 | Data line value driven by the host |
| dbg_oe | output | 1 | Host owns the data line |
| id_req | output | 1 | Request to the packet engine for the ID-code read |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two pairs of events can meet in one cycle. The first is a start request that arrives while a sequence is running. The bench raises the opposite request partway through a switch sequence and partway through a reset sequence. It then requires that the captured bit stream has exactly the length and content of the sequence that was first requested. The second is both requests raised in the same idle cycle. The bench checks that the full switch stream follows and that `id_req` appears, which a reset-only sequence never produces.

// File: rtl/swd_switch_seq.sv
module swd_switch_seq #(
  parameter int RST_CLKS  = 56,
  parameter int IDLE_CLKS = 8,
  parameter int HALF_DIV  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_switch,
  input  logic start_reset,
  input  logic id_ack,
  output logic dbg_clk,
  output logic dbg_out,
  output logic dbg_oe,
  output logic id_req,
  output logic busy,
  output logic done
);
  localparam int PAT_LEN = 16;
  localparam logic [PAT_LEN-1:0] PAT = 16'h79E7;
  localparam int MAXC = (RST_CLKS > IDLE_CLKS) ? ((RST_CLKS > PAT_LEN) ? RST_CLKS : PAT_LEN)
                                               : ((IDLE_CLKS > PAT_LEN) ? IDLE_CLKS : PAT_LEN);
  localparam int CW = $clog2(MAXC + 1);
  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  typedef enum logic [2:0] {S_IDLE, S_RST1, S_SEL, S_RST2, S_LOW, S_ID} st_t;

  st_t st;
  logic full_mode, ph, done_q;
  logic [HW-1:0] hc;
  logic [CW-1:0] bitn, len;

  wire running = (st == S_RST1) || (st == S_SEL) || (st == S_RST2) || (st == S_LOW);
  wire half_end = (hc == HW'(HALF_DIV - 1));
  wire bit_end = running && ph && half_end;
  wire last_bit = (bitn == len - 1'b1);

  always_comb begin
    case (st)
      S_SEL:   len = CW'(PAT_LEN);
      S_LOW:   len = CW'(IDLE_CLKS);
      default: len = CW'(RST_CLKS);
    endcase
  end

  always_comb begin
    case (st)
      S_RST1, S_RST2: dbg_out = 1'b1;
      S_SEL:          dbg_out = PAT[PAT_LEN - 1 - int'(bitn)];
      default:        dbg_out = 1'b0;
    endcase
  end

  assign dbg_clk = ph;
  assign dbg_oe  = running;
  assign id_req  = (st == S_ID);
  assign busy    = (st != S_IDLE);
  assign done    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      full_mode <= 1'b0;
      ph <= 1'b0;
      hc <= '0;
      bitn <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st == S_IDLE) begin
        ph <= 1'b0;
        hc <= '0;
        bitn <= '0;
        if (start_switch) begin
          st <= S_RST1;
          full_mode <= 1'b1;
        end else if (start_reset) begin
          st <= S_RST2;
          full_mode <= 1'b0;
        end
      end else if (st == S_ID) begin
        if (id_ack) begin
          st <= S_IDLE;
          done_q <= 1'b1;
        end
      end else begin
        if (half_end) begin
          hc <= '0;
          ph <= ~ph;
        end else begin
          hc <= hc + 1'b1;
        end
        if (bit_end) begin
          if (last_bit) begin
            bitn <= '0;
            case (st)
              S_RST1: st <= S_SEL;
              S_SEL:  st <= S_RST2;
              S_RST2: st <= S_LOW;
              default: begin
                st <= full_mode ? S_ID : S_IDLE;
                done_q <= !full_mode;
              end
            endcase
          end else begin
            bitn <= bitn + 1'b1;
          end
        end
      end
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dbg_oe && !dbg_clk && !id_req));

  // R2
  switch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_switch) |=> (busy && dbg_oe && dbg_out && !dbg_clk));

  // R6
  handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_req |-> (!dbg_oe && !dbg_clk));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_clk && $past(dbg_clk)) |-> $stable(dbg_out));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/swd_switch_seq_bench.sv
module swd_switch_seq_bench;
  localparam int RST = 51;
  localparam int IDL = 3;
  localparam int HALF = 2;
  localparam int SW_LEN = 2 * RST + 16 + IDL;
  localparam int RS_LEN = RST + IDL;

  logic clk = 0, rst_n = 0;
  logic start_switch = 0, start_reset = 0, id_ack = 0;
  logic dbg_clk, dbg_out, dbg_oe, id_req, busy, done;

  int checks = 0, fails = 0;
  int cnt = 0, cyc = 0, last_rise = 0;
  bit id_seen = 0, finished = 0;
  logic cap [0:255];
  logic prev_clk = 0, prev_out = 0;

  always #5 clk = ~clk;

  swd_switch_seq #(.RST_CLKS(RST), .IDLE_CLKS(IDL), .HALF_DIV(HALF)) u_swd_switch_seq (
    .clk(clk), .rst_n(rst_n), .start_switch(start_switch), .start_reset(start_reset),
    .id_ack(id_ack), .dbg_clk(dbg_clk), .dbg_out(dbg_out), .dbg_oe(dbg_oe),
    .id_req(id_req), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (id_req) id_seen = 1;
    if (dbg_clk && prev_clk && dbg_out !== prev_out)
      chk(0, "R8 data moved while clock high", dbg_out, prev_out);
    if (dbg_clk && !prev_clk) begin
      if (cnt > 0) chk(cyc - last_rise == 2 * HALF, "R8 clock period", cyc - last_rise, 2 * HALF);
      if (cnt < 256) cap[cnt] = dbg_out;
      cnt++;
      last_rise = cyc;
    end
    prev_clk = dbg_clk;
    prev_out = dbg_out;
  end

  function automatic logic exp_bit(input bit full, input int i);
    logic [15:0] pat = 16'h79E7;
    if (!full) return (i < RST) ? 1'b1 : 1'b0;
    if (i < RST) return 1'b1;
    if (i < RST + 16) return pat[15 - (i - RST)];
    if (i < 2 * RST + 16) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run(input bit sw, input bit rs, input bit inject);
    bit full = sw;
    int lim = full ? SW_LEN : RS_LEN;
    cnt = 0;
    id_seen = 0;
    @(negedge clk);
    start_switch = sw;
    start_reset = rs;
    @(negedge clk);
    start_switch = 0;
    start_reset = 0;
    for (int k = 0; k < 5000 && !(id_req || done); k++) begin
      @(negedge clk);
      if (inject && k == 30) begin
        start_switch = !full;
        start_reset = full;
      end else begin
        start_switch = 0;
        start_reset = 0;
      end
    end
    // R5 total clock count, R9 injected request ignored
    chk(cnt == lim, "R5/R9 edge count", cnt, lim);
    for (int i = 0; i < lim && i < 256; i++) begin
      if (full && i < RST) chk(cap[i] === exp_bit(full, i), "R2 first reset", cap[i], exp_bit(full, i));
      else if (full && i < RST + 16) chk(cap[i] === exp_bit(full, i), "R3 select", cap[i], exp_bit(full, i));
      else if (full && i < 2 * RST + 16) chk(cap[i] === exp_bit(full, i), "R4 second reset", cap[i], exp_bit(full, i));
      else if (full) chk(cap[i] === exp_bit(full, i), "R5 idle", cap[i], exp_bit(full, i));
      else chk(cap[i] === exp_bit(full, i), "R7 reset only", cap[i], exp_bit(full, i));
    end
    if (full) begin
      chk(id_req === 1'b1, "R6 id_req raised", id_req, 1);
      repeat (7) @(negedge clk);
      chk(id_req && !dbg_oe && !dbg_clk && !done, "R6 held while waiting", {id_req, dbg_oe, dbg_clk, done}, 4'b1000);
      id_ack = 1;
      @(negedge clk);
      id_ack = 0;
      chk(done === 1'b1, "R6 done after ack", done, 1);
    end else begin
      chk(done === 1'b1 && !id_seen, "R7 done without id_req", {done, id_seen}, 2'b10);
    end
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R10 single pulse", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!dbg_clk && !dbg_oe && !busy && !id_req && !done, "R1 reset state",
        {dbg_clk, dbg_oe, busy, id_req, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!dbg_clk && !dbg_oe && !busy && !id_req && !done, "R1 idle after release",
        {dbg_clk, dbg_oe, busy, id_req, done}, 0);
    run(1, 0, 0);
    run(0, 1, 0);
    run(1, 0, 1);
    run(0, 1, 1);
    run(1, 1, 0); // R9 simultaneous requests pick the switch sequence
    repeat (4) @(negedge clk);
    chk(!busy && !dbg_oe, "R1 quiet at end", {busy, dbg_oe}, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule